// File: doc/BRIEF.md
# Trace Debug Byte Serializer

A small bus-mapped peripheral for debug tracing. A processor writes bytes into it, and it shifts each byte out on a serial clock and serial data pin pair, where an external capture tool records it. The block has two registers. The control word sets the enable, the launch edge of the serial clock, the serial clock ratio and the idle gap between bytes. The data word accepts the next byte, and when read it reports transmit status.

A one-byte holding buffer sits between the bus and the shift engine. A byte written while another byte is on the wire waits in this buffer. When the buffer is already occupied, a further data write is held off with wait states and is never lost. Each bit lasts one full serial clock period, 2, 4 or 8 bus clocks long. After every byte the engine keeps the pins idle for a programmable gap of 1 to 8 bus clocks before it starts the next byte. Every byte value, the packet-start marker 0xFD included, is passed through unchanged.

Top module: `tdb_serializer`

## Requirements
- R1: After reset, ser_clk and ser_dat are both high, busy is low and the control register reads zero. Whenever no byte is being shifted, both serial pins are high.
- R2: The control register sits at byte offset 4. Bit 0 is enable, bit 1 is edge select, bits 3:2 are the clock code and bits 6:4 are the gap. A read returns only these 7 bits; bits 31:7 read zero.
- R3: When enabled, a write to offset 0 places bits 7:0 in the holding buffer. The first bit appears on ser_dat one bus clock after the accepting edge. Bits go out least significant first, one per serial clock period, 8 in total.
- R4: Clock code 0 gives a serial period of 2 bus clocks, code 1 gives 4, code 2 gives 8, and code 3 gives 2 like code 0.
- R5: With edge select 0, ser_clk is high in the first half of each bit and low in the second half, so ser_dat changes together with a rising edge. With edge select 1, ser_clk is low in the first half and high in the second half, so ser_dat changes with a falling edge.
- R6: When the next byte is already buffered, exactly gap+1 bus clocks with both pins high separate the last bit period of one byte from the first bit of the next.
- R7: A read of offset 0 returns busy in bit 0 (a byte is shifting, in its gap, or buffered) and buffer-full in bit 1. The busy output equals bit 0.
- R8: A data write that arrives while the holding buffer is full drives bus_ready low until the buffer empties. The byte is then accepted, and every such byte is transmitted.
- R9: Clearing enable aborts the current byte. Within one bus clock of the accepting edge of the control write, the pins return high, the buffer empties and busy drops. Data writes made while disabled complete without wait states and are discarded.
- R10: The byte 0xFD is shifted out like any other value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe for this block |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_ready | output | 1 | Low inserts a wait state |
| ser_clk | output | 1 | Serial clock to the capture tool |
| ser_dat | output | 1 | Serial data to the capture tool |
| busy | output | 1 | A byte is queued, shifting or in its gap |

## Verification
A byte accepted on edge W shows its first bit after edge W+1, and bit k of an N-clock serial period covers the cycles from W+1+kN to W+(k+1)N. The bench therefore samples ser_clk and ser_dat at every falling clock edge from that point and compares each sample with the level worked out for it. Status reads are combinational and are checked in the cycle after W (buffer still full) and again one cycle later (buffer drained into the shifter). A disable takes effect on the edge after the control write, so the idle pins and the empty status are sampled two falling edges after the write. Gaps and lost bytes are measured by counting the lengths of high and low runs on ser_dat while all-zero bytes stream out.

// File: rtl/tdb_pkg.sv
package tdb_pkg;

   localparam int CTRL_W = 7;
   localparam int GAP_W  = 3;
   localparam int CNT_W  = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_GAP   = 2'd2
   } eng_state_t;

   typedef struct packed {
      logic [GAP_W-1:0] gap;
      logic [1:0]       div;
      logic             edge_f;
      logic             en;
   } ctrl_t;

   // last count value of one half serial period
   function automatic logic [CNT_W-1:0] half_last(input logic [1:0] code);
      case (code)
         2'd1:    return CNT_W'(1);
         2'd2:    return CNT_W'(3);
         default: return CNT_W'(0);
      endcase
   endfunction

endpackage

// File: rtl/tdb_regs.sv
module tdb_regs
   import tdb_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 32,
   parameter int BYTE_W   = 8,
   parameter int DATA_OFF = 0,
   parameter int CTRL_OFF = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   input  logic              take,
   input  logic              eng_busy,
   output ctrl_t             ctrl_q,
   output logic [BYTE_W-1:0] buf_byte,
   output logic              buf_full
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFF);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFF);

   if (DATA_W < BYTE_W || DATA_W < CTRL_W) begin : g_bad_width
      $error("tdb_regs: DATA_W too narrow");
   end
   if (DATA_OFF == CTRL_OFF) begin : g_bad_map
      $error("tdb_regs: register offsets collide");
   end

   logic wr_data, wr_ctrl;
   logic unused_wdata;

   assign wr_data      = bus_sel && bus_wr && (bus_addr == A_DATA);
   assign wr_ctrl      = bus_sel && bus_wr && (bus_addr == A_CTRL);
   assign bus_ready    = !(wr_data && buf_full);
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         buf_byte <= '0;
         buf_full <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
         if (!ctrl_q.en) begin
            buf_full <= 1'b0;
         end else if (wr_data && !buf_full) begin
            buf_byte <= bus_wdata[BYTE_W-1:0];
            buf_full <= 1'b1;
         end else if (take) begin
            buf_full <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_sel && !bus_wr) begin
         if (bus_addr == A_CTRL) begin
            bus_rdata[CTRL_W-1:0] = ctrl_q;
         end else if (bus_addr == A_DATA) begin
            bus_rdata[0] = eng_busy || buf_full;
            bus_rdata[1] = buf_full;
         end
      end
   end

endmodule

// File: rtl/tdb_clkdiv.sv
module tdb_clkdiv
   import tdb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [1:0] div_code,
   output logic       half_tick
);

   logic [CNT_W-1:0] cnt;

   assign half_tick = run && (cnt >= half_last(div_code));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (half_tick)  cnt <= '0;
      else                 cnt <= cnt + CNT_W'(1);
   end

endmodule

// File: rtl/tdb_shifter.sv
module tdb_shifter
   import tdb_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              edge_f,
   input  logic [GAP_W-1:0]  gap,
   input  logic              half_tick,
   input  logic              buf_full,
   input  logic [BYTE_W-1:0] buf_byte,
   output logic              take,
   output logic              shifting,
   output logic              eng_busy,
   output logic              ser_clk,
   output logic              ser_dat
);

   localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("tdb_shifter: BYTE_W must be at least 2");
   end

   eng_state_t        state;
   logic [BYTE_W-1:0] shreg, shreg_nx;
   logic [BIT_W-1:0]  bitn;
   logic [GAP_W-1:0]  gcnt;
   logic              phase, head;

   if (LSB_FIRST) begin : g_lsb
      assign head     = shreg[0];
      assign shreg_nx = {1'b0, shreg[BYTE_W-1:1]};
   end else begin : g_msb
      assign head     = shreg[BYTE_W-1];
      assign shreg_nx = {shreg[BYTE_W-2:0], 1'b0};
   end

   assign take     = en && buf_full &&
                     ((state == ST_IDLE) || ((state == ST_GAP) && (gcnt == gap)));
   assign shifting = (state == ST_SHIFT);
   assign eng_busy = (state != ST_IDLE);
   assign ser_dat  = shifting ? head : 1'b1;
   assign ser_clk  = shifting ? (phase ^ !edge_f) : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         shreg <= '0;
         bitn  <= '0;
         gcnt  <= '0;
         phase <= 1'b0;
      end else if (!en) begin
         state <= ST_IDLE;
         bitn  <= '0;
         gcnt  <= '0;
         phase <= 1'b0;
      end else begin
         if (take) begin
            state <= ST_SHIFT;
            shreg <= buf_byte;
            bitn  <= '0;
            phase <= 1'b0;
         end else begin
            case (state)
               ST_SHIFT: if (half_tick) begin
                  if (!phase) begin
                     phase <= 1'b1;
                  end else begin
                     phase <= 1'b0;
                     shreg <= shreg_nx;
                     bitn  <= bitn + BIT_W'(1);
                     if (bitn == LAST_BIT) begin
                        state <= ST_GAP;
                        gcnt  <= '0;
                     end
                  end
               end
               ST_GAP: begin
                  if (gcnt == gap) state <= ST_IDLE;
                  else             gcnt  <= gcnt + GAP_W'(1);
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/tdb_serializer.sv
module tdb_serializer
   import tdb_pkg::*;
#(
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 32,
   parameter int BYTE_W    = 8,
   parameter int DATA_OFF  = 0,
   parameter int CTRL_OFF  = 4,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_ready,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              busy
);

   ctrl_t             ctrl_q;
   logic [BYTE_W-1:0] buf_byte;
   logic              buf_full, take, shifting, eng_busy, half_tick, en_q;

   assign en_q = ctrl_q.en;
   assign busy = eng_busy || buf_full;

   tdb_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W),
      .DATA_OFF(DATA_OFF), .CTRL_OFF(CTRL_OFF)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
      .take(take), .eng_busy(eng_busy),
      .ctrl_q(ctrl_q), .buf_byte(buf_byte), .buf_full(buf_full)
   );

   tdb_clkdiv u_div (
      .clk(clk), .rst_n(rst_n), .run(shifting),
      .div_code(ctrl_q.div), .half_tick(half_tick)
   );

   tdb_shifter #(.BYTE_W(BYTE_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .en(en_q), .edge_f(ctrl_q.edge_f),
      .gap(ctrl_q.gap), .half_tick(half_tick),
      .buf_full(buf_full), .buf_byte(buf_byte),
      .take(take), .shifting(shifting), .eng_busy(eng_busy),
      .ser_clk(ser_clk), .ser_dat(ser_dat)
   );

endmodule

// File: rtl/tdb_serializer_chk.sv
module tdb_serializer_chk
   import tdb_pkg::*;
#(
   parameter int ADDR_W   = 3,
   parameter int DATA_W   = 32,
   parameter int DATA_OFF = 0,
   parameter int CTRL_OFF = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_ready,
   input logic              ser_clk,
   input logic              ser_dat,
   input logic              busy,
   input logic              en,
   input logic              buf_full,
   input logic              take,
   input logic              shifting
);

   localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(DATA_OFF);
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFF);

   // R2: upper control bits always read as zero
   p_ctrl_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr == A_CTRL) |-> (bus_rdata[DATA_W-1:CTRL_W] == '0));

   // R5: data only moves together with a serial clock transition
   p_data_with_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (shifting && $past(shifting) && (ser_dat != $past(ser_dat)))
         |-> (ser_clk != $past(ser_clk)));

   // R7: an accepted data write makes the block report busy
   p_busy_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr == A_DATA && bus_ready && en) |=> busy);

   // R8: wait states only for a data write meeting a full buffer
   p_stall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ready |-> (bus_sel && bus_wr && bus_addr == A_DATA && buf_full));

   // R8: a buffered byte stays until the engine takes it
   p_no_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_full && en && !take) |=> buf_full);

   // R9: once disabled for a cycle, the pins are idle and nothing is pending
   p_disabled_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !$past(en)) |-> (ser_clk && ser_dat && !busy));

endmodule

bind tdb_serializer tdb_serializer_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_OFF(DATA_OFF), .CTRL_OFF(CTRL_OFF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
   .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy), .en(en_q),
   .buf_full(buf_full), .take(take), .shifting(shifting)
);

// File: tb/tdb_serializer_tb.sv
`timescale 1ns/1ps
module tdb_serializer_tb;

   localparam int A_DATA = 0;
   localparam int A_CTRL = 4;

   // {clock code[13:12], edge select[11], gap[10:8], byte[7:0]}
   localparam int NVEC = 6;
   localparam logic [13:0] VEC [NVEC] = '{
      {2'd0, 1'b0, 3'd0, 8'hA5},
      {2'd1, 1'b0, 3'd2, 8'h3C},
      {2'd2, 1'b1, 3'd1, 8'h81},
      {2'd3, 1'b1, 3'd0, 8'hFD},
      {2'd0, 1'b1, 3'd4, 8'h00},
      {2'd2, 1'b0, 3'd7, 8'hFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ready, ser_clk, ser_dat, busy;

   int  n_checks = 0;
   int  n_errors = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   tdb_serializer u_dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ready(bus_ready), .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy)
   );

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [31:0] cw(input bit en, input bit ef,
                                      input logic [1:0] dc, input logic [2:0] g);
      return {25'b0, g, dc, ef, en};
   endfunction

   function automatic int period(input logic [1:0] dc);
      return (dc == 2'd1) ? 4 : (dc == 2'd2) ? 8 : 2;
   endfunction

   // returns just after the accepting rising edge
   task automatic bus_write(input int addr, input logic [31:0] data, output int stalls);
      bit ok;
      stalls = 0;
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(addr); bus_wdata = data;
      forever begin
         #2 ok = bus_ready;
         @(posedge clk);
         if (ok) break;
         stalls++;
      end
      #1 bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input int addr, output logic [31:0] data);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(addr);
      #2 data = bus_rdata;
      bus_sel = 1'b0;
   endtask

   // write one byte, then compare every bus-clock sample of the waveform
   task automatic send_and_check(input logic [1:0] dc, input bit ef,
                                 input logic [7:0] b, input string rq);
      int dv, st, bad;
      logic [1:0] act, exp, fa, fe;
      dv = period(dc);
      bad = 0; fa = '0; fe = '0;
      bus_write(A_DATA, {24'b0, b}, st);
      @(negedge clk);
      for (int k = 0; k < 8 * dv; k++) begin
         @(negedge clk);
         exp = {((k % dv) >= dv / 2) ? ef : !ef, b[k / dv]};
         act = {ser_clk, ser_dat};
         if (act !== exp && bad == 0) begin fa = act; fe = exp; end
         if (act !== exp) bad++;
      end
      check(bad == 0, rq, "serial waveform {clk,dat}", {30'b0, fa}, {30'b0, fe});
      @(negedge clk);
      check({ser_clk, ser_dat} == 2'b11, "R1", "pins idle after byte",
            {30'b0, ser_clk, ser_dat}, 32'h3);
   endtask

   // watch ser_dat while all-zero bytes stream out
   task automatic watch_zero_bytes(input int cycles, input int dv, output int runs,
                                   output int gmin, output int gmax, output int badlen);
      int zlen, hlen;
      runs = 0; gmin = 9999; gmax = 0; badlen = 0; zlen = 0; hlen = 0;
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         if (!ser_dat) begin
            if (zlen == 0) begin
               runs++;
               if (runs > 1) begin
                  if (hlen < gmin) gmin = hlen;
                  if (hlen > gmax) gmax = hlen;
               end
            end
            zlen++; hlen = 0;
         end else begin
            if (zlen != 0 && zlen != 8 * dv) badlen++;
            zlen = 0; hlen++;
         end
      end
   endtask

   task automatic gap_test(input logic [2:0] g);
      int st, s1, s2, s3, runs, gmin, gmax, badlen;
      bus_write(A_CTRL, cw(1'b1, 1'b1, 2'd0, g), st);
      fork
         watch_zero_bytes(120, 2, runs, gmin, gmax, badlen);
         begin
            bus_write(A_DATA, 32'h0, s1);
            bus_write(A_DATA, 32'h0, s2);
            bus_write(A_DATA, 32'h0, s3);
         end
      join
      check(gmin == int'(g) + 1 && gmax == int'(g) + 1, "R6", "idle gap between bytes",
            32'(gmin), 32'(int'(g) + 1));
      check(s3 > 0, "R8", "third write held by wait states", 32'(s3), 32'd1);
      check(runs == 3 && badlen == 0, "R8", "bytes transmitted (none dropped)",
            32'(runs), 32'd3);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      int st;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      check({ser_clk, ser_dat, busy} == 3'b110, "R1", "pins/busy after reset",
            {29'b0, ser_clk, ser_dat, busy}, 32'h6);
      bus_read(A_CTRL, rd);
      check(rd == 32'h0, "R1", "control after reset", rd, 32'h0);
      bus_read(A_DATA, rd);
      check(rd == 32'h0, "R7", "status after reset", rd, 32'h0);

      // R2: only 7 control bits kept
      bus_write(A_CTRL, 32'hFFFF_FFFF, st);
      bus_read(A_CTRL, rd);
      check(rd == 32'h7F, "R2", "control readback masked", rd, 32'h7F);
      bus_write(A_CTRL, 32'h0000_002A, st);
      bus_read(A_CTRL, rd);
      check(rd == 32'h2A, "R2", "control readback pattern", rd, 32'h2A);

      // table walk: R3 R4 R5 waveform under each clock code and edge
      for (int i = 0; i < NVEC; i++) begin
         bus_write(A_CTRL, cw(1'b1, VEC[i][11], VEC[i][13:12], VEC[i][10:8]), st);
         send_and_check(VEC[i][13:12], VEC[i][11], VEC[i][7:0],
                        (VEC[i][7:0] == 8'hFD) ? "R10" : "R3/R4/R5");
         repeat (12) @(negedge clk);
      end

      // R7: status read while buffered, then while shifting, then idle
      bus_write(A_CTRL, cw(1'b1, 1'b1, 2'd2, 3'd0), st);
      bus_write(A_DATA, 32'h0000_0055, st);
      bus_read(A_DATA, rd);
      check(rd == 32'h3, "R7", "status with byte buffered", rd, 32'h3);
      bus_read(A_DATA, rd);
      check(rd == 32'h1, "R7", "status while shifting", rd, 32'h1);
      check(busy == 1'b1, "R7", "busy output while shifting", {31'b0, busy}, 32'h1);
      repeat (80) @(negedge clk);
      bus_read(A_DATA, rd);
      check(rd == 32'h0, "R7", "status after drain", rd, 32'h0);

      // R6 / R8: gap length and back-pressure
      gap_test(3'd0);
      repeat (10) @(negedge clk);
      gap_test(3'd7);
      repeat (10) @(negedge clk);

      // R9: abort mid-byte with a second byte buffered
      bus_write(A_CTRL, cw(1'b1, 1'b1, 2'd2, 3'd0), st);
      bus_write(A_DATA, 32'h0, st);
      bus_write(A_DATA, 32'h0, st);
      repeat (10) @(negedge clk);
      bus_write(A_CTRL, cw(1'b0, 1'b1, 2'd2, 3'd0), st);
      @(negedge clk);
      @(negedge clk);
      check({ser_clk, ser_dat, busy} == 3'b110, "R9", "pins idle after abort",
            {29'b0, ser_clk, ser_dat, busy}, 32'h6);
      bus_read(A_DATA, rd);
      check(rd == 32'h0, "R9", "buffer emptied by abort", rd, 32'h0);
      bus_write(A_DATA, 32'h0000_005A, st);
      check(st == 0, "R9", "no wait state while disabled", 32'(st), 32'h0);
      @(negedge clk);
      @(negedge clk);
      bus_read(A_DATA, rd);
      check(rd == 32'h0 && !busy, "R9", "disabled write discarded", rd, 32'h0);
      bus_write(A_CTRL, cw(1'b1, 1'b1, 2'd2, 3'd0), st);
      begin
         int moved = 0;
         for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (!ser_clk || !ser_dat) moved++;
         end
         check(moved == 0, "R9", "nothing sent after re-enable", 32'(moved), 32'h0);
      end

      finished = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule